// File: doc/BRIEF.md
# Sensor Start-up and Scan Sequencer

This block drives a register-frame transceiver so that an SPI accelerometer or inclinometer is brought up and then read. After reset it sends a software-reset write to the sensor and waits a programmable settling time. It then reads the identity register and decides which device variant is attached. When the inclinometer variant is found, it also switches the angle outputs on. Once start-up is complete, each trigger pulse makes the block read the data registers of the detected variant in a fixed order. The words are gathered into a staging buffer and published together with a one-cycle strobe.

The transceiver can report two kinds of problem. A return-status error means the sensor has flagged a fault. The sequencer handles it by issuing a single read of the status register, which clears the error, and it captures the low status bits. A transport failure, such as a checksum mismatch, abandons the current operation. During start-up it latches a device fault, and during a scan it drops the sample. A narrow direct register port lets a requester read or write a single register while the sequencer is idle. Any address outside the 5-bit register space is refused. Triggers that arrive while a scan is still running are dropped and counted in a saturating counter.

Top module: `sensor_scan_seq`

## Requirements
- R1: The first transaction after reset is a write of 0x0020 to register 0x0D.
- R2: At least SETTLE_CYCLES clock cycles pass between the response to the reset write and the next request.
- R3: The second transaction reads register 0x10. A value of 0x0051 selects the basic variant (variant_incl=0) and sets init_done. A value of 0x00C1 selects the inclinometer variant (variant_incl=1). Any other value sets dev_fault, leaves init_done low, and stops all further requests.
- R4: Only for the inclinometer variant, start-up writes 0x001F to register 0x0C before init_done rises. The basic variant makes no third start-up transaction.
- R5: A trigger accepted while idle reads registers 0x01, 0x02, 0x03 and 0x05 in that order. The inclinometer variant then also reads 0x09, 0x0A and 0x0B. Only after all reads complete does sample_valid pulse for one cycle. Channel k of this order sits in sample_data[16k+15:16k]. The unused channels 4 to 6 read zero for the basic variant.
- R6: A response flagged with xrs_err is followed at once by one read of register 0x06. That read's data bits [8:0] appear on status_bits with a one-cycle status_valid pulse. Its own status flag is not treated as a new error. The word returned by the flagged transaction is kept and used.
- R7: A transport failure (xfail) during a scan abandons the scan, so no sample_valid follows. A transport failure during start-up sets dev_fault.
- R8: A direct access with acc_addr above 0x1F finishes the next cycle with acc_done and acc_err and starts no transaction. A valid direct access performs one read or write of that register and returns the read word on acc_rdata with acc_err low.
- R9: Every cycle in which trigger is high during a running scan adds one to overrun_cnt. The counter stops at 2^OVR_W-1 and never decreases until reset.
- R10: xreq is high for single cycles only, and no new request is issued before the previous one has received xdone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trigger | input | 1 | Start a scan when idle |
| acc_req | input | 1 | Direct access request, sampled when idle |
| acc_we | input | 1 | Direct access is a write |
| acc_addr | input | REQ_ADDR_W | Direct access register address |
| acc_wdata | input | 16 | Direct access write word |
| xdone | input | 1 | Transceiver response strobe |
| xrdata | input | 16 | Response data word |
| xrs_err | input | 1 | Response carries sensor status error |
| xfail | input | 1 | Response transport failure |
| xreq | output | 1 | Transaction request strobe |
| xwe | output | 1 | Request is a write |
| xaddr | output | 5 | Request register address |
| xwdata | output | 16 | Request write word |
| seq_idle | output | 1 | Sequencer idle and able to accept work |
| init_done | output | 1 | Start-up completed |
| variant_incl | output | 1 | Inclinometer variant detected |
| dev_fault | output | 1 | Unknown identity or start-up transport failure |
| sample_valid | output | 1 | One-cycle sample strobe |
| sample_data | output | 16*NCH_FULL | Packed signed channel words |
| status_valid | output | 1 | One-cycle status capture strobe |
| status_bits | output | STAT_W | Captured device status |
| acc_done | output | 1 | Direct access finished |
| acc_err | output | 1 | Direct access refused or failed |
| acc_rdata | output | 16 | Direct access read word |
| overrun_cnt | output | OVR_W | Saturating count of dropped triggers |

## Verification
Assertions check the request protocol on every cycle: single-cycle requests, status reads issued only right after a flagged response, a single-cycle sample strobe that never comes before start-up finishes, and silence after a fault. They also check immediate refusal of out-of-range direct addresses and counter saturation and monotonicity. Other behaviour can only be shown by the bench's scenarios: the start-up order and settling gap, variant selection from the identity word, the scan address order, the word values placed in each channel, the retained word after a status recovery, and the dropped sample after a transport failure.

// File: rtl/ssq_pkg.sv
package ssq_pkg;
   localparam int DW = 16;
   localparam int FA_W = 5;

   localparam logic [FA_W-1:0] A_MODE  = 5'h0D;
   localparam logic [FA_W-1:0] A_STAT  = 5'h06;
   localparam logic [FA_W-1:0] A_IDENT = 5'h10;
   localparam logic [FA_W-1:0] A_ANGLE = 5'h0C;

   localparam logic [DW-1:0] V_SWRST  = 16'h0020;
   localparam logic [DW-1:0] V_ANG_ON = 16'h001F;
   localparam logic [DW-1:0] ID_BASIC = 16'h0051;
   localparam logic [DW-1:0] ID_INCL  = 16'h00C1;

   typedef enum logic [2:0] {
      S_ISSUE, S_WAIT, S_STAT_ISSUE, S_STAT_WAIT, S_SETTLE, S_IDLE, S_FAULT
   } st_t;

   typedef enum logic [2:0] {
      OP_RST, OP_IDENT, OP_ANGLE, OP_SCAN, OP_ACC
   } op_t;

   // scan position to register address: accel 1..3, temperature 5, angles 9..11
   function automatic logic [FA_W-1:0] scan_addr(input logic [2:0] k);
      if (k < 3'd3)       return {2'b00, k} + 5'd1;
      else if (k == 3'd3) return 5'h05;
      else                return {2'b00, k} + 5'd5;
   endfunction
endpackage

// File: rtl/ssq_settle_timer.sv
module ssq_settle_timer #(
   parameter int LIMIT = 2600000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic done
);
   localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);

   if (LIMIT < 1) begin : g_bad_limit
      $error("LIMIT must be at least 1");
   end

   logic          running;
   logic [CW-1:0] cnt;

   assign done = running && (cnt == CW'(LIMIT - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running <= 1'b0;
         cnt     <= '0;
      end else if (start) begin
         running <= 1'b1;
         cnt     <= '0;
      end else if (running) begin
         if (done) running <= 1'b0;
         else      cnt     <= cnt + 1'b1;
      end
   end

   // R2
   start_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && LIMIT > 1) |=> !done);
endmodule

// File: rtl/ssq_sat_counter.sv
module ssq_sat_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] count
);
   localparam logic [W-1:0] MAXV = {W{1'b1}};

   if (W < 1) begin : g_bad_w
      $error("W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                   count <= '0;
      else if (inc && count != MAXV) count <= count + 1'b1;
   end

   // R9
   sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (count == MAXV) |=> (count == MAXV));
   // R9
   ovr_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count >= $past(count));
endmodule

// File: rtl/ssq_sample_buf.sv
module ssq_sample_buf #(
   parameter int NCH = 7,
   parameter int DW  = 16,
   parameter int IW  = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [IW-1:0]   wr_idx,
   input  logic [DW-1:0]   wr_data,
   input  logic            pub,
   output logic            sample_valid,
   output logic [NCH*DW-1:0] sample_data
);
   if (NCH > (1 << IW)) begin : g_bad_iw
      $error("IW too narrow for NCH");
   end

   logic signed [DW-1:0] stage [NCH];

   for (genvar k = 0; k < NCH; k++) begin : g_ch
      logic hit;
      assign hit = wr_en && (wr_idx == IW'(k));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            stage[k]                  <= '0;
            sample_data[k*DW +: DW]   <= '0;
         end else begin
            if (hit) stage[k] <= wr_data;
            if (pub) sample_data[k*DW +: DW] <= hit ? wr_data : stage[k];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) sample_valid <= 1'b0;
      else        sample_valid <= pub;
   end

   // R5
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sample_valid |=> !sample_valid);
endmodule

// File: rtl/sensor_scan_seq.sv
module sensor_scan_seq
   import ssq_pkg::*;
#(
   parameter int REQ_ADDR_W    = 8,
   parameter int SETTLE_CYCLES = 2600000,
   parameter int OVR_W         = 8,
   parameter int NCH_BASIC     = 4,
   parameter int NCH_FULL      = 7,
   parameter int STAT_W        = 9
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     trigger,
   input  logic                     acc_req,
   input  logic                     acc_we,
   input  logic [REQ_ADDR_W-1:0]    acc_addr,
   input  logic [15:0]              acc_wdata,
   input  logic                     xdone,
   input  logic [15:0]              xrdata,
   input  logic                     xrs_err,
   input  logic                     xfail,
   output logic                     xreq,
   output logic                     xwe,
   output logic [4:0]               xaddr,
   output logic [15:0]              xwdata,
   output logic                     seq_idle,
   output logic                     init_done,
   output logic                     variant_incl,
   output logic                     dev_fault,
   output logic                     sample_valid,
   output logic [16*NCH_FULL-1:0]   sample_data,
   output logic                     status_valid,
   output logic [STAT_W-1:0]        status_bits,
   output logic                     acc_done,
   output logic                     acc_err,
   output logic [15:0]              acc_rdata,
   output logic [OVR_W-1:0]         overrun_cnt
);
   localparam int IDX_W = 3;
   localparam logic [REQ_ADDR_W-1:0] MAX_ADDR = REQ_ADDR_W'((1 << FA_W) - 1);

   if (NCH_BASIC >= NCH_FULL || NCH_FULL > 7 || NCH_BASIC < 1) begin : g_bad_nch
      $error("channel counts out of range");
   end
   if (STAT_W > DW || STAT_W < 1) begin : g_bad_stat
      $error("STAT_W out of range");
   end
   if (REQ_ADDR_W < FA_W) begin : g_bad_aw
      $error("REQ_ADDR_W narrower than frame address");
   end

   st_t              state;
   op_t              op;
   logic [IDX_W-1:0] idx;
   logic [DW-1:0]    hold;
   logic [FA_W-1:0]  acc_addr_r;
   logic             acc_we_r;
   logic [DW-1:0]    acc_wd_r;

   logic             resp_ok, resp_fail, settle_done, settle_start;
   logic [DW-1:0]    resp_word;
   logic [IDX_W-1:0] last_idx;
   logic             scan_busy, buf_wr, buf_pub;

   // request fields from the current operation context
   always_comb begin
      xwe    = 1'b0;
      xwdata = '0;
      xaddr  = A_STAT;
      if (state == S_ISSUE) begin
         case (op)
            OP_RST:   begin xaddr = A_MODE;  xwe = 1'b1; xwdata = V_SWRST;  end
            OP_IDENT: begin xaddr = A_IDENT; end
            OP_ANGLE: begin xaddr = A_ANGLE; xwe = 1'b1; xwdata = V_ANG_ON; end
            OP_SCAN:  begin xaddr = scan_addr(idx); end
            OP_ACC:   begin xaddr = acc_addr_r; xwe = acc_we_r; xwdata = acc_wd_r; end
            default:  begin xaddr = A_STAT; end
         endcase
      end
   end

   assign xreq      = (state == S_ISSUE) || (state == S_STAT_ISSUE);
   assign seq_idle  = (state == S_IDLE);
   assign resp_ok   = xdone && !xfail &&
                      (((state == S_WAIT) && !xrs_err) || (state == S_STAT_WAIT));
   assign resp_fail = xdone && xfail && ((state == S_WAIT) || (state == S_STAT_WAIT));
   assign resp_word = (state == S_STAT_WAIT) ? hold : xrdata;
   assign last_idx  = variant_incl ? IDX_W'(NCH_FULL - 1) : IDX_W'(NCH_BASIC - 1);
   assign scan_busy = (op == OP_SCAN) &&
                      (state == S_ISSUE || state == S_WAIT ||
                       state == S_STAT_ISSUE || state == S_STAT_WAIT);
   assign settle_start = resp_ok && (op == OP_RST);
   assign buf_wr    = resp_ok && (op == OP_SCAN);
   assign buf_pub   = buf_wr && (idx == last_idx);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state        <= S_ISSUE;
         op           <= OP_RST;
         idx          <= '0;
         hold         <= '0;
         variant_incl <= 1'b0;
         init_done    <= 1'b0;
         dev_fault    <= 1'b0;
         status_valid <= 1'b0;
         status_bits  <= '0;
         acc_done     <= 1'b0;
         acc_err      <= 1'b0;
         acc_rdata    <= '0;
         acc_addr_r   <= '0;
         acc_we_r     <= 1'b0;
         acc_wd_r     <= '0;
      end else begin
         status_valid <= 1'b0;
         acc_done     <= 1'b0;
         acc_err      <= 1'b0;
         case (state)
            S_ISSUE:      state <= S_WAIT;
            S_STAT_ISSUE: state <= S_STAT_WAIT;
            S_WAIT: begin
               if (xdone && !xfail && xrs_err) begin
                  hold  <= xrdata;
                  state <= S_STAT_ISSUE;
               end
            end
            S_STAT_WAIT: begin
               if (xdone && !xfail) begin
                  status_bits  <= xrdata[STAT_W-1:0];
                  status_valid <= 1'b1;
               end
            end
            S_SETTLE: begin
               if (settle_done) begin
                  op    <= OP_IDENT;
                  state <= S_ISSUE;
               end
            end
            S_IDLE: begin
               if (trigger) begin
                  op    <= OP_SCAN;
                  idx   <= '0;
                  state <= S_ISSUE;
               end else if (acc_req) begin
                  if (acc_addr > MAX_ADDR) begin
                     acc_done <= 1'b1;
                     acc_err  <= 1'b1;
                  end else begin
                     acc_addr_r <= acc_addr[FA_W-1:0];
                     acc_we_r   <= acc_we;
                     acc_wd_r   <= acc_wdata;
                     op         <= OP_ACC;
                     state      <= S_ISSUE;
                  end
               end
            end
            default: state <= state;
         endcase

         if (resp_ok) begin
            case (op)
               OP_RST: state <= S_SETTLE;
               OP_IDENT: begin
                  if (resp_word == ID_BASIC) begin
                     variant_incl <= 1'b0;
                     init_done    <= 1'b1;
                     state        <= S_IDLE;
                  end else if (resp_word == ID_INCL) begin
                     variant_incl <= 1'b1;
                     op           <= OP_ANGLE;
                     state        <= S_ISSUE;
                  end else begin
                     dev_fault <= 1'b1;
                     state     <= S_FAULT;
                  end
               end
               OP_ANGLE: begin
                  init_done <= 1'b1;
                  state     <= S_IDLE;
               end
               OP_SCAN: begin
                  if (idx == last_idx) state <= S_IDLE;
                  else begin
                     idx   <= idx + 1'b1;
                     state <= S_ISSUE;
                  end
               end
               OP_ACC: begin
                  acc_done  <= 1'b1;
                  acc_rdata <= resp_word;
                  state     <= S_IDLE;
               end
               default: state <= S_FAULT;
            endcase
         end

         if (resp_fail) begin
            case (op)
               OP_SCAN: state <= S_IDLE;
               OP_ACC: begin
                  acc_done <= 1'b1;
                  acc_err  <= 1'b1;
                  state    <= S_IDLE;
               end
               default: begin
                  dev_fault <= 1'b1;
                  state     <= S_FAULT;
               end
            endcase
         end
      end
   end

   ssq_settle_timer #(.LIMIT(SETTLE_CYCLES)) u_settle (
      .clk   (clk),
      .rst_n (rst_n),
      .start (settle_start),
      .done  (settle_done)
   );

   ssq_sat_counter #(.W(OVR_W)) u_ovr (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (trigger && scan_busy),
      .count (overrun_cnt)
   );

   ssq_sample_buf #(.NCH(NCH_FULL), .DW(DW), .IW(IDX_W)) u_buf (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (buf_wr),
      .wr_idx       (idx),
      .wr_data      (resp_word),
      .pub          (buf_pub),
      .sample_valid (sample_valid),
      .sample_data  (sample_data)
   );

   // R10
   req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xreq |=> !xreq);
   // R5
   valid_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sample_valid |-> init_done);
   // R6
   stat_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_STAT_ISSUE) |-> $past(xdone && xrs_err && !xfail));
   // R8
   reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_idle && !trigger && acc_req && acc_addr > MAX_ADDR)
      |=> (acc_done && acc_err && !xreq));
   // R3
   fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dev_fault |-> (!xreq && !sample_valid && !init_done));
endmodule

// File: tb/tb_sensor_scan_seq.sv
module tb_sensor_scan_seq;
   localparam int SETTLE = 40;
   localparam int OVRW   = 3;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n = 1'b0, trigger = 1'b0, acc_req = 1'b0, acc_we = 1'b0;
   logic [7:0] acc_addr = '0;
   logic [15:0] acc_wdata = '0;
   logic xdone, xrs_err, xfail;
   logic [15:0] xrdata;
   logic xreq, xwe, seq_idle, init_done, variant_incl, dev_fault;
   logic sample_valid, status_valid, acc_done, acc_err;
   logic [4:0] xaddr;
   logic [15:0] xwdata, acc_rdata;
   logic [111:0] sample_data;
   logic [8:0] status_bits;
   logic [OVRW-1:0] overrun_cnt;

   sensor_scan_seq #(.SETTLE_CYCLES(SETTLE), .OVR_W(OVRW)) dut (
      .clk(clk), .rst_n(rst_n), .trigger(trigger), .acc_req(acc_req),
      .acc_we(acc_we), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
      .xdone(xdone), .xrdata(xrdata), .xrs_err(xrs_err), .xfail(xfail),
      .xreq(xreq), .xwe(xwe), .xaddr(xaddr), .xwdata(xwdata),
      .seq_idle(seq_idle), .init_done(init_done), .variant_incl(variant_incl),
      .dev_fault(dev_fault), .sample_valid(sample_valid), .sample_data(sample_data),
      .status_valid(status_valid), .status_bits(status_bits), .acc_done(acc_done),
      .acc_err(acc_err), .acc_rdata(acc_rdata), .overrun_cnt(overrun_cnt)
   );

   int total = 0, bad = 0, cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // sensor / transceiver model state
   logic [15:0] regs [32];
   logic [15:0] ident, stat_word;
   int lat_fix = 0;
   logic [4:0] inj_rs_addr, inj_fail_addr;
   bit inj_rs_on = 0, inj_fail_on = 0, proto_err = 0;
   int nlog = 0, nstat = 0, nsamp = 0, nacc = 0;
   logic [4:0] log_a [256];
   logic log_w [256];
   logic [15:0] log_d [256];
   int log_c [256], rsp_c [256];
   logic [8:0] last_stat;
   logic [111:0] last_samp;
   logic last_acc_err;
   logic [15:0] last_acc_d;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   function automatic int exp_addr(input int k);
      if (k < 3) return k + 1;
      if (k == 3) return 5;
      return k + 5;
   endfunction

   function automatic logic [111:0] exp_sample(input bit incl);
      logic [111:0] v = '0;
      for (int k = 0; k < (incl ? 7 : 4); k++) v[k*16 +: 16] = regs[exp_addr(k)];
      return v;
   endfunction

   initial begin
      int pend, cnt, cur;
      pend = 0; cnt = 0; cur = 0;
      xdone = 0; xrdata = '0; xrs_err = 0; xfail = 0;
      forever begin
         @(negedge clk);
         if (!rst_n) begin
            xdone = 0; xrs_err = 0; xfail = 0; pend = 0;
         end else begin
            if (xdone) begin xdone = 0; xrs_err = 0; xfail = 0; end
            if (sample_valid) begin nsamp++; last_samp = sample_data; end
            if (status_valid) begin nstat++; last_stat = status_bits; end
            if (acc_done) begin nacc++; last_acc_err = acc_err; last_acc_d = acc_rdata; end
            if (pend != 0) begin
               cnt--;
               if (cnt == 0) begin
                  pend = 0;
                  xdone = 1;
                  rsp_c[cur] = cyc;
                  if (log_w[cur]) begin
                     regs[log_a[cur]] = log_d[cur];
                     xrdata = '0;
                  end else if (log_a[cur] == 5'h06) begin
                     xrdata = stat_word; xrs_err = 1;
                  end else if (log_a[cur] == 5'h10) xrdata = ident;
                  else xrdata = regs[log_a[cur]];
                  if (inj_fail_on && log_a[cur] == inj_fail_addr) begin
                     xfail = 1; inj_fail_on = 0;
                  end
                  if (inj_rs_on && !log_w[cur] && log_a[cur] == inj_rs_addr) begin
                     xrs_err = 1; inj_rs_on = 0;
                  end
               end
            end
            if (xreq) begin
               if (pend != 0) proto_err = 1;
               cur = nlog;
               log_a[cur] = xaddr; log_w[cur] = xwe; log_d[cur] = xwdata; log_c[cur] = cyc;
               if (nlog < 255) nlog++;
               pend = 1;
               cnt = (lat_fix != 0) ? lat_fix : 1 + int'($urandom % 3);
            end
         end
      end
   end

   task automatic do_reset(input logic [15:0] id);
      ident = id;
      @(negedge clk);
      rst_n = 0;
      nlog = 0;
      repeat (4) @(negedge clk);
      @(posedge clk);
      #1 rst_n = 1;
   endtask

   task automatic wait_init();
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if (init_done || dev_fault) break;
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic rand_regs();
      for (int a = 1; a < 12; a++) regs[a] = 16'($urandom);
   endtask

   // trigger held for 1+extra cycles; returns whether a sample appeared
   task automatic do_scan(input int extra, output bit got, output int first);
      int n0;
      n0 = nsamp;
      @(negedge clk);
      while (!seq_idle) @(negedge clk);
      first = nlog;
      trigger = 1;
      repeat (1 + extra) @(negedge clk);
      trigger = 0;
      for (int i = 0; i < 400; i++) begin
         if (nsamp > n0 || (seq_idle && i > 2)) break;
         @(negedge clk);
      end
      repeat (2) @(negedge clk);
      got = (nsamp > n0);
   endtask

   task automatic do_acc(input bit we, input logic [7:0] a, input logic [15:0] d);
      int n0;
      n0 = nacc;
      @(negedge clk);
      while (!seq_idle) @(negedge clk);
      acc_req = 1; acc_we = we; acc_addr = a; acc_wdata = d;
      @(negedge clk);
      acc_req = 0;
      for (int i = 0; i < 100; i++) begin
         if (nacc > n0) break;
         @(negedge clk);
      end
   endtask

   initial begin
      #(150000 * 10);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      bit got;
      int s, n0, ns0;
      void'($urandom(32'd20240611));
      for (int a = 0; a < 32; a++) regs[a] = 16'($urandom);
      stat_word = 16'h01A5;

      // reset values
      ident = 16'h0051;
      @(negedge clk);
      chk(!init_done && !sample_valid && !dev_fault, "R3", "reset init/fault", {init_done, dev_fault}, 0);
      chk(overrun_cnt == 0, "R9", "reset overrun", overrun_cnt, 0);

      // basic variant start-up
      do_reset(16'h0051);
      wait_init();
      chk(log_a[0] == 5'h0D && log_w[0] && log_d[0] == 16'h0020, "R1", "reset write",
          {log_a[0], log_w[0], log_d[0]}, {5'h0D, 1'b1, 16'h0020});
      chk(log_c[1] - rsp_c[0] >= SETTLE, "R2", "settle gap", log_c[1] - rsp_c[0], SETTLE);
      chk(log_a[1] == 5'h10 && !log_w[1], "R3", "ident read", log_a[1], 5'h10);
      chk(init_done && !variant_incl && !dev_fault, "R3", "basic selected",
          {init_done, variant_incl, dev_fault}, 3'b100);
      chk(nlog == 2, "R4", "no angle write for basic", nlog, 2);

      // random basic scans
      for (int i = 0; i < 12; i++) begin
         rand_regs();
         do_scan(0, got, s);
         chk(got, "R5", "basic sample published", got, 1);
         chk(last_samp == exp_sample(0), "R5", "basic sample words", last_samp, exp_sample(0));
         chk(nlog - s == 4, "R5", "basic read count", nlog - s, 4);
         for (int k = 0; k < 4; k++)
            chk(int'(log_a[s+k]) == exp_addr(k) && !log_w[s+k], "R5", "scan order",
                log_a[s+k], exp_addr(k));
      end

      // status error recovery mid-scan
      rand_regs();
      stat_word = 16'($urandom);
      ns0 = nstat;
      inj_rs_addr = 5'h02; inj_rs_on = 1;
      do_scan(0, got, s);
      chk(nstat == ns0 + 1, "R6", "one status capture", nstat - ns0, 1);
      chk(last_stat == stat_word[8:0], "R6", "status bits", last_stat, stat_word[8:0]);
      chk(log_a[s+1] == 5'h02 && log_a[s+2] == 5'h06 && log_a[s+3] == 5'h03, "R6",
          "status read placement", {log_a[s+1], log_a[s+2], log_a[s+3]}, {5'h02, 5'h06, 5'h03});
      chk(nlog - s == 5, "R6", "single recovery read", nlog - s, 5);
      chk(got && last_samp == exp_sample(0), "R6", "flagged word kept", last_samp, exp_sample(0));

      // transport failure mid-scan
      rand_regs();
      inj_fail_addr = 5'h03; inj_fail_on = 1;
      do_scan(0, got, s);
      chk(!got, "R7", "failed scan publishes nothing", got, 0);
      chk(seq_idle && !dev_fault, "R7", "idle after abandoned scan", {seq_idle, dev_fault}, 2'b10);

      // overrun counting and saturation
      lat_fix = 4;
      rand_regs();
      do_scan(3, got, s);
      chk(overrun_cnt == 3, "R9", "overrun three", overrun_cnt, 3);
      chk(got && last_samp == exp_sample(0), "R9", "scan unaffected by extra triggers",
          last_samp, exp_sample(0));
      do_scan(10, got, s);
      chk(overrun_cnt == 7, "R9", "overrun saturates", overrun_cnt, 7);
      lat_fix = 0;

      // direct access
      n0 = nlog;
      do_acc(0, 8'h25, 16'h0);
      chk(last_acc_err && nlog == n0, "R8", "out-of-range refused", {last_acc_err, nlog - n0}, 1 << 32);
      do_acc(0, 8'h07, 16'h0);
      chk(!last_acc_err && last_acc_d == regs[7], "R8", "direct read", last_acc_d, regs[7]);
      chk(nlog == n0 + 1 && log_a[n0] == 5'h07, "R8", "direct read frame", log_a[n0], 5'h07);
      do_acc(1, 8'h0E, 16'hBEEF);
      chk(log_w[n0+1] && log_a[n0+1] == 5'h0E && log_d[n0+1] == 16'hBEEF, "R8", "direct write frame",
          {log_w[n0+1], log_a[n0+1], log_d[n0+1]}, {1'b1, 5'h0E, 16'hBEEF});

      // transport failure during start-up
      inj_fail_addr = 5'h10; inj_fail_on = 1;
      do_reset(16'h0051);
      wait_init();
      chk(dev_fault && !init_done, "R7", "start-up failure faults", {dev_fault, init_done}, 2'b10);

      // unknown identity
      do_reset(16'h0077);
      wait_init();
      chk(dev_fault && !init_done, "R3", "unknown identity", {dev_fault, init_done}, 2'b10);
      n0 = nlog; ns0 = nsamp;
      @(negedge clk); trigger = 1; @(negedge clk); trigger = 0;
      repeat (30) @(negedge clk);
      chk(nlog == n0 && nsamp == ns0, "R3", "no activity after fault", nlog - n0, 0);

      // inclinometer variant
      do_reset(16'h00C1);
      wait_init();
      chk(variant_incl && init_done, "R3", "inclinometer selected", {variant_incl, init_done}, 2'b11);
      chk(nlog == 3 && log_a[2] == 5'h0C && log_w[2] && log_d[2] == 16'h001F, "R4", "angle enable write",
          {log_a[2], log_w[2], log_d[2]}, {5'h0C, 1'b1, 16'h001F});
      chk(overrun_cnt == 0, "R9", "overrun cleared by reset", overrun_cnt, 0);
      for (int i = 0; i < 8; i++) begin
         rand_regs();
         do_scan(0, got, s);
         chk(got && last_samp == exp_sample(1), "R5", "incl sample words", last_samp, exp_sample(1));
         chk(nlog - s == 7, "R5", "incl read count", nlog - s, 7);
         for (int k = 0; k < 7; k++)
            chk(int'(log_a[s+k]) == exp_addr(k), "R5", "incl scan order", log_a[s+k], exp_addr(k));
      end

      chk(!proto_err, "R10", "no overlapping requests", proto_err, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule